// File: doc/BRIEF.md
# Exception Entry Controller

This block computes the architectural state a 32-bit RISC core adopts when it enters an exception handler. Each cycle it may see any mix of eight request lines: reset, undefined instruction, software interrupt, prefetch abort, data abort, address exception, IRQ and FIQ. When the accept strobe `take` is high and at least one line is set, it picks one cause by fixed priority. From the current PC and status word it then produces the new status word, the saved-status write (bank and value), the link value and the handler PC. All outputs change together on the next clock edge.

The `legacy26` input selects the legacy 26-bit configuration. In that configuration most exceptions fall back to supervisor mode. The PC word carries the flags, the interrupt masks and the mode alongside the address. The core's fetch, register storage and exception return all live outside this block.

Top module: `trap_entry`

## Requirements
- R1: While `rst` is high (synchronous), the outputs become: `psr_out` = 0xD3, or 0xC3 when `legacy26` is 1; `pc_out` = 0, or 0x0C000003 when `legacy26` is 1; `link_out`, `spsr_val`, `spsr_bank` and `cause_out` = 0; `taken`, `spsr_we` and `pabt_flag` = 0.
- R2: Cause codes are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, address exception 5, IRQ 6, FIQ 7, and `req[k]` carries code k. Among the set lines the winner is chosen in the order reset, data abort, FIQ, IRQ, prefetch abort, address exception, undefined, software interrupt. One cycle after an accepted request, `taken` = 1 and `cause_out` holds the winner.
- R3: Every entry sets the IRQ mask (status bit 7). Reset and FIQ also set the FIQ mask (bit 6). All other causes keep bit 6 as it was. Bits 31:8 and bit 5 are carried over unchanged.
- R4: The base value is formed as follows. With `legacy26` = 1 it is {psr[31:28], psr[7:6], pc[25:2], psr[1:0]}. With `legacy26` = 0 and psr[4] = 0 it is pc with bits 31:26 and 1:0 cleared. Otherwise it is pc itself. `link_out` is that base for reset and the base minus 4 (modulo 2^32) for every other cause.
- R5: With `legacy26` = 0 the new mode (bits 4:0) is: reset and software interrupt 0x13; undefined 0x1B; both aborts 0x17; IRQ 0x12; FIQ 0x11.
- R6: With `legacy26` = 1 the new mode is 0x03 for reset, undefined, software interrupt and both aborts; 0x02 for IRQ; 0x01 for FIQ.
- R7: The address exception always enters mode 0x03 and saves into the supervisor bank, in either configuration.
- R8: The vector is the cause code times 4. If bit 4 of the new mode is 1, `pc_out` equals the vector. Otherwise `pc_out` = {new psr[31:28], new psr[7:6], 26'b0} OR vector OR new mode[1:0].
- R9: An entry pulses `spsr_we` for one cycle and sets `spsr_val` to the pre-entry `cur_psr`. `spsr_bank` is FIQ 1, IRQ 2, supervisor 3, abort 4, undefined 5. Undefined uses bank 5 and aborts use bank 4 with `legacy26` = 0; both use bank 3 with `legacy26` = 1. Reset and software interrupt use bank 3.
- R10: A cycle with `take` low or no request line set has no effect: the next cycle shows `taken` = 0, `spsr_we` = 0, `pabt_flag` = 0, and all other outputs keep their values.
- R11: `pabt_flag` is 1 for exactly the cycle after a prefetch-abort entry and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy26 | input | 1 | 1 selects the legacy 26-bit configuration |
| take | input | 1 | Accept strobe for the pending requests |
| req | input | 8 | Request lines, bit k is cause code k |
| cur_pc | input | 32 | PC at the point of the exception |
| cur_psr | input | 32 | Status word at the point of the exception |
| taken | output | 1 | An entry was performed on the last edge |
| cause_out | output | 3 | Cause code of the last entry |
| psr_out | output | 32 | New status word |
| pc_out | output | 32 | Handler PC (vector, merged in 26-bit mode) |
| link_out | output | 32 | Value for the link register |
| spsr_we | output | 1 | Saved-status write enable pulse |
| spsr_bank | output | 3 | Saved-status bank select |
| spsr_val | output | 32 | Saved-status value |
| pabt_flag | output | 1 | Prefetch-abort entry marker |

## Verification
The bench targets the following corner cases:
- **Simultaneous requests.** An arbiter with the wrong order shows a different `cause_out` and vector.
- **Address exception under the 32-bit configuration.** A design that follows the configuration here enters 0x13 with a plain vector instead of the merged 26-bit word.
- **A PC of zero or near zero.** The minus-4 link must wrap, and a design that saturates or drops the borrow gives a wrong link value.
- **A 26-bit current mode while in the 32-bit configuration.** A design that ignores the mode bit leaves the high PC bits in the link value.
- **Idle cycles with stray request lines but no strobe.** These expose a design that updates outputs or pulses the write enable without `take`.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int NCAUSE = 8;
    localparam int CW     = $clog2(NCAUSE);
    localparam int XW     = 32;
    localparam int VEC_SH = 2;

    typedef enum logic [CW-1:0] {
        C_RST  = 3'd0,
        C_UND  = 3'd1,
        C_SWI  = 3'd2,
        C_PABT = 3'd3,
        C_DABT = 3'd4,
        C_ADDR = 3'd5,
        C_IRQ  = 3'd6,
        C_FIQ  = 3'd7
    } cause_e;

    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

    localparam logic [4:0] M_FIQ   = 5'h11;
    localparam logic [4:0] M_IRQ   = 5'h12;
    localparam logic [4:0] M_SVC   = 5'h13;
    localparam logic [4:0] M_ABT   = 5'h17;
    localparam logic [4:0] M_UND   = 5'h1B;
    localparam logic [4:0] M26_FIQ = 5'h01;
    localparam logic [4:0] M26_IRQ = 5'h02;
    localparam logic [4:0] M26_SVC = 5'h03;

    localparam int PSR_I = 7;
    localparam int PSR_F = 6;

    localparam logic [XW-1:0] PSR_RST32 = 32'h0000_00D3;
    localparam logic [XW-1:0] PSR_RST26 = 32'h0000_00C3;
    localparam logic [XW-1:0] PC_RST32  = 32'h0000_0000;
    localparam logic [XW-1:0] PC_RST26  = 32'h0C00_0003;

    // highest priority first
    localparam logic [CW-1:0] PRIO_LIST [NCAUSE] = '{
        3'd0, 3'd4, 3'd7, 3'd6, 3'd3, 3'd5, 3'd1, 3'd2
    };

    typedef struct packed {
        logic [4:0] mode;
        bank_e      bank;
        logic       set_f;
        logic       adj;
    } route_t;

    typedef struct packed {
        logic [XW-1:0] psr;
        logic [XW-1:0] pc;
        logic [XW-1:0] link;
    } entry_t;

    function automatic logic [XW-1:0] vec_addr(input cause_e c);
        return XW'(c) << VEC_SH;
    endfunction

endpackage

// File: rtl/trap_arb.sv
module trap_arb
    import trap_pkg::*;
(
    input  logic [NCAUSE-1:0] req,
    output logic              hit,
    output cause_e            sel
);
    always_comb begin
        hit = |req;
        sel = C_RST;
        for (int k = NCAUSE - 1; k >= 0; k--) begin
            if (req[PRIO_LIST[k]]) sel = cause_e'(PRIO_LIST[k]);
        end
    end
endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
(
    input  cause_e cause,
    input  logic   legacy26,
    output route_t rt
);
    always_comb begin
        rt.set_f = (cause == C_RST) || (cause == C_FIQ);
        rt.adj   = (cause != C_RST);
        unique case (cause)
            C_RST, C_SWI: begin
                rt.mode = legacy26 ? M26_SVC : M_SVC;
                rt.bank = BK_SVC;
            end
            C_UND: begin
                rt.mode = legacy26 ? M26_SVC : M_UND;
                rt.bank = legacy26 ? BK_SVC : BK_UND;
            end
            C_PABT, C_DABT: begin
                rt.mode = legacy26 ? M26_SVC : M_ABT;
                rt.bank = legacy26 ? BK_SVC : BK_ABT;
            end
            C_ADDR: begin
                rt.mode = M26_SVC;
                rt.bank = BK_SVC;
            end
            C_IRQ: begin
                rt.mode = legacy26 ? M26_IRQ : M_IRQ;
                rt.bank = BK_IRQ;
            end
            default: begin
                rt.mode = legacy26 ? M26_FIQ : M_FIQ;
                rt.bank = BK_FIQ;
            end
        endcase
    end
endmodule

// File: rtl/trap_pcword.sv
module trap_pcword
    import trap_pkg::*;
(
    input  cause_e        cause,
    input  route_t        rt,
    input  logic          legacy26,
    input  logic [XW-1:0] cur_pc,
    input  logic [XW-1:0] cur_psr,
    output entry_t        ent
);
    localparam logic [XW-1:0] LINK_ADJ = XW'(4);

    logic [XW-1:0] base;
    logic [XW-1:0] vec;

    always_comb begin
        if (legacy26)
            base = {cur_psr[31:28], cur_psr[PSR_I:PSR_F], cur_pc[25:2], cur_psr[1:0]};
        else if (!cur_psr[4])
            base = {6'b0, cur_pc[25:2], 2'b0};
        else
            base = cur_pc;

        ent.link = rt.adj ? (base - LINK_ADJ) : base;

        ent.psr = {cur_psr[XW-1:8], 1'b1, rt.set_f | cur_psr[PSR_F], cur_psr[5], rt.mode};

        vec = vec_addr(cause);
        if (ent.psr[4])
            ent.pc = vec;
        else
            ent.pc = {ent.psr[31:28], ent.psr[PSR_I:PSR_F], 26'b0} | vec | {30'b0, ent.psr[1:0]};
    end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
    import trap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          legacy26,
    input  logic          take,
    input  logic [7:0]    req,
    input  logic [31:0]   cur_pc,
    input  logic [31:0]   cur_psr,
    output logic          taken,
    output logic [2:0]    cause_out,
    output logic [31:0]   psr_out,
    output logic [31:0]   pc_out,
    output logic [31:0]   link_out,
    output logic          spsr_we,
    output logic [2:0]    spsr_bank,
    output logic [31:0]   spsr_val,
    output logic          pabt_flag
);
    logic   hit;
    cause_e sel;
    route_t rt;
    entry_t ent;
    logic   go;

    trap_arb u_arb (.req(req), .hit(hit), .sel(sel));
    trap_route u_route (.cause(sel), .legacy26(legacy26), .rt(rt));
    trap_pcword u_pcw (
        .cause(sel), .rt(rt), .legacy26(legacy26),
        .cur_pc(cur_pc), .cur_psr(cur_psr), .ent(ent)
    );

    assign go = take && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken     <= 1'b0;
            cause_out <= '0;
            psr_out   <= legacy26 ? PSR_RST26 : PSR_RST32;
            pc_out    <= legacy26 ? PC_RST26 : PC_RST32;
            link_out  <= '0;
            spsr_we   <= 1'b0;
            spsr_bank <= BK_NONE;
            spsr_val  <= '0;
            pabt_flag <= 1'b0;
        end else begin
            taken     <= go;
            spsr_we   <= go;
            pabt_flag <= go && (sel == C_PABT);
            if (go) begin
                cause_out <= sel;
                psr_out   <= ent.psr;
                pc_out    <= ent.pc;
                link_out  <= ent.link;
                spsr_bank <= rt.bank;
                spsr_val  <= cur_psr;
            end
        end
    end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        legacy26,
    input logic        take,
    input logic [7:0]  req,
    input logic [31:0] cur_pc,
    input logic [31:0] cur_psr,
    input logic        taken,
    input logic [2:0]  cause_out,
    input logic [31:0] psr_out,
    input logic [31:0] pc_out,
    input logic [31:0] link_out,
    input logic        spsr_we,
    input logic        pabt_flag
);
    AST_PRIO_RESET: assert property (@(posedge clk) disable iff (rst)
        taken && $past(req[0]) |-> cause_out == 3'd0); // R2

    AST_IMASK_SET: assert property (@(posedge clk) disable iff (rst)
        taken |-> psr_out[7]); // R3

    AST_FIQ_FMASK: assert property (@(posedge clk) disable iff (rst)
        taken && cause_out == 3'd7 |-> psr_out[6]); // R3

    AST_LINK_MINUS4: assert property (@(posedge clk) disable iff (rst)
        taken && cause_out != 3'd0 && $past(!legacy26) && $past(cur_psr[4])
        |-> link_out == $past(cur_pc) - 32'd4); // R4

    AST_ADDR_SVC26: assert property (@(posedge clk) disable iff (rst)
        taken && cause_out == 3'd5 |-> psr_out[4:0] == 5'h03); // R7

    AST_WE_PAIRED: assert property (@(posedge clk) disable iff (rst)
        spsr_we |-> taken); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(take && (|req))
        |-> !spsr_we && $stable(pc_out) && $stable(psr_out) && $stable(link_out)); // R10

    AST_PABT_FLAG: assert property (@(posedge clk) disable iff (rst)
        pabt_flag |-> taken && cause_out == 3'd3); // R11
endmodule

bind trap_entry trap_entry_chk u_chk (.*);

// File: tb/trap_entry_tb.sv
module trap_entry_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, legacy26, take;
    logic [7:0]  req;
    logic [31:0] cur_pc, cur_psr;
    logic        taken, spsr_we, pabt_flag;
    logic [2:0]  cause_out, spsr_bank;
    logic [31:0] psr_out, pc_out, link_out, spsr_val;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // expected state
    logic [31:0] e_psr, e_pc, e_link, e_sval;
    logic [2:0]  e_cause, e_bank;
    logic        e_taken, e_we, e_pabt;
    string       ctx;
    int          e_c;

    trap_entry u_dut (
        .clk(clk), .rst(rst), .legacy26(legacy26), .take(take), .req(req),
        .cur_pc(cur_pc), .cur_psr(cur_psr), .taken(taken), .cause_out(cause_out),
        .psr_out(psr_out), .pc_out(pc_out), .link_out(link_out), .spsr_we(spsr_we),
        .spsr_bank(spsr_bank), .spsr_val(spsr_val), .pabt_flag(pabt_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s (%s): actual=%h expected=%h at %0t", tag, what, ctx, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string tm, tr;
        vectors++;
        if (ctx == "reset") begin
            tm = "R1"; tr = "R1";
        end else if (ctx == "idle") begin
            tm = "R10"; tr = "R10";
        end else begin
            tr = "R2";
            tm = (e_c == 5) ? "R7" : (legacy_used ? "R6" : "R5");
        end
        cmp(tr, "taken", {31'b0, taken}, {31'b0, e_taken});
        cmp(tr, "cause", {29'b0, cause_out}, {29'b0, e_cause});
        cmp(tm, "mode", {27'b0, psr_out[4:0]}, {27'b0, e_psr[4:0]});
        cmp(ctx == "entry" ? "R3" : tr, "psr", psr_out, e_psr);
        cmp(ctx == "entry" ? "R8" : tr, "pc", pc_out, e_pc);
        cmp(ctx == "entry" ? "R4" : tr, "link", link_out, e_link);
        cmp(ctx == "entry" ? "R9" : tr, "spsr_we", {31'b0, spsr_we}, {31'b0, e_we});
        cmp(ctx == "entry" ? "R9" : tr, "spsr_bank", {29'b0, spsr_bank}, {29'b0, e_bank});
        cmp(ctx == "entry" ? "R9" : tr, "spsr_val", spsr_val, e_sval);
        cmp(ctx == "entry" ? "R11" : tr, "pabt_flag", {31'b0, pabt_flag}, {31'b0, e_pabt});
    endtask

    bit legacy_used;

    // behavioural reference for one accepted cycle
    task automatic model_step();
        int order[$] = '{0, 4, 7, 6, 3, 5, 1, 2};
        int c, m, bk;
        logic [31:0] base, vec;
        if (rst) begin
            ctx = "reset";
            e_taken = 0; e_we = 0; e_pabt = 0; e_cause = 0;
            e_psr  = legacy26 ? 32'hC3 : 32'hD3;
            e_pc   = legacy26 ? 32'h0C000003 : 32'h0;
            e_link = 0; e_bank = 0; e_sval = 0;
            return;
        end
        if (!take || req == 8'h00) begin
            ctx = "idle";
            e_taken = 0; e_we = 0; e_pabt = 0;
            return;
        end
        ctx = "entry";
        legacy_used = legacy26;
        c = -1;
        foreach (order[i]) if (c < 0 && req[order[i]]) c = order[i];
        e_c = c;
        if (c == 5) m = 3;
        else if (legacy26) m = (c == 6) ? 2 : (c == 7) ? 1 : 3;
        else case (c)
            1: m = 'h1B;
            3, 4: m = 'h17;
            6: m = 'h12;
            7: m = 'h11;
            default: m = 'h13;
        endcase
        case (c)
            1: bk = legacy26 ? 3 : 5;
            3, 4: bk = legacy26 ? 3 : 4;
            6: bk = 2;
            7: bk = 1;
            default: bk = 3;
        endcase
        if (legacy26)
            base = (cur_psr & 32'hF0000000) | (((cur_psr >> 6) & 3) << 26) | (cur_pc & 32'h03FFFFFC) | (cur_psr & 3);
        else if (cur_psr[4] == 1'b0)
            base = cur_pc & 32'h03FFFFFC;
        else
            base = cur_pc;
        e_link = (c == 0) ? base : base - 32'd4;
        e_psr = (cur_psr & ~32'hDF) | 32'h80 | ((c == 0 || c == 7) ? 32'h40 : (cur_psr & 32'h40)) | 32'(m);
        vec = 32'(c * 4);
        if (m >= 16) e_pc = vec;
        else e_pc = (e_psr & 32'hF0000000) | (((e_psr >> 6) & 3) << 26) | vec | 32'(m & 3);
        e_taken = 1; e_we = 1; e_pabt = (c == 3);
        e_cause = 3'(c); e_bank = 3'(bk); e_sval = cur_psr;
    endtask

    // drive one cycle: set inputs at negedge, update model, compare after posedge
    task automatic cyc(bit r, bit l, bit t, logic [7:0] q, logic [31:0] pc, logic [31:0] psr);
        rst = r; legacy26 = l; take = t; req = q; cur_pc = pc; cur_psr = psr;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        ctx = "reset"; e_c = 0; legacy_used = 0;
        @(negedge clk);
        // R1 reset state, both configurations
        cyc(1, 0, 0, 8'h00, 32'h0, 32'h0);
        cyc(1, 1, 0, 8'h00, 32'h0, 32'h0);
        cyc(1, 0, 0, 8'h00, 32'h0, 32'h0);
        // R10 stray requests without strobe
        cyc(0, 0, 0, 8'hFF, 32'h1234, 32'h10);
        // R2 all lines: reset wins; R11 prefetch abort alone
        cyc(0, 0, 1, 8'hFF, 32'h8000, 32'hF000001F);
        cyc(0, 0, 1, 8'hFE, 32'h8000, 32'h10);   // data abort wins
        cyc(0, 0, 1, 8'hEE, 32'h8000, 32'h10);   // FIQ
        cyc(0, 0, 1, 8'h6E, 32'h8000, 32'h10);   // IRQ
        cyc(0, 0, 1, 8'h2E, 32'h8000, 32'h10);   // prefetch abort, R11
        cyc(0, 0, 1, 8'h26, 32'h8000, 32'h10);   // address exception, R7
        cyc(0, 0, 1, 8'h06, 32'h8000, 32'h10);   // undefined
        cyc(0, 0, 1, 8'h04, 32'h8000, 32'h10);   // software interrupt
        cyc(0, 0, 1, 8'h00, 32'h8000, 32'h10);   // strobe with no request, R10
        // every cause alone in both configurations, R5 R6 R8 R9
        for (int l = 0; l < 2; l++)
            for (int c = 0; c < 8; c++)
                cyc(0, l[0], 1, 8'(1 << c), 32'h0400_0124, 32'hA000_0053);
        // R4 borrow at PC 0 and 26-bit current mode in 32-bit configuration
        cyc(0, 0, 1, 8'h02, 32'h0, 32'h13);
        cyc(0, 0, 1, 8'h40, 32'hFFFF_FF00, 32'h6000_0002);
        cyc(0, 1, 1, 8'h80, 32'h0, 32'h0);
        // R7 address exception under the 32-bit configuration
        cyc(0, 0, 1, 8'h20, 32'h100, 32'h5000_001F);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] q;
            q = 8'($urandom) & 8'($urandom);
            if (($urandom % 4) != 0) q[0] = 1'b0;
            cyc(($urandom % 97) == 0, ($urandom % 3) == 0, ($urandom % 3) != 0,
                q, $urandom, $urandom);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule